// File: doc/BRIEF.md
# GPIO Input Deglitch Filter

This block cleans up the level of a single general-purpose input before it is reported as the pin's status bit. It runs on the system clock and counts a slow real-time tick strobe. The strobe is a one-cycle enable at the real-time clock rate, typically 32.768 kHz. The raw pin first passes through a two-flop synchronizer. A filter then decides when the reported level may follow the synchronized input.

Three groups of configuration bits control the filter. A 2-bit mode selects one of four behaviours: pass-through, keep low pulses, keep high pulses, or reject pulses of both polarities. Two time-base bits select how many ticks make one unit: 2, 8, 512 or 2048. A 4-bit count sets how many units a new level must stay stable before it is accepted. Any change to these bits restarts the timing and keeps the reported level for that cycle.

Top module: `gpio_deglitch`

## Requirements
- R1: While and after reset, until the input has propagated, `pin_level` is 0.
- R2: The input reaches the filter through two synchronizing flops, and `pin_level` is registered. So `pin_level` only ever takes the value `pin_raw` had three clock edges earlier.
- R3: With `cfg_mode` = 00 (pass-through), `pin_level` follows `pin_raw` with a latency of exactly three clock edges, and `rtc_tick` has no effect.
- R4: The time-base bits {`cfg_large`,`cfg_unit`} select the ticks per unit: 00 gives 2, 01 gives 8, 10 gives 512, 11 gives 2048.
- R5: With `cfg_mode` = 11 (reject both), a new synchronized level is accepted on the clock edge that samples the `cfg_count`×unit-th tick seen while the level differs from `pin_level`. Without a tick, `pin_level` does not change.
- R6: If the synchronized input returns to the level of `pin_level` before the time expires, the progress is discarded, and the next change needs the full time again.
- R7: With `cfg_mode` = 01 (keep low pulses), a fall of the synchronized input is passed on at once. A rise must be stable for the full time.
- R8: With `cfg_mode` = 10 (keep high pulses), a rise is passed on at once and a fall must be stable for the full time.
- R9: In a filtering mode with `cfg_count` = 0, every change is passed on at once, with the pass-through latency.
- R10: On a clock edge where any configuration bit differs from its value at the previous edge, `pin_level` holds and the tick and unit counters restart from zero.
- R11: The largest count, 15, with the 2-tick unit, needs exactly 30 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rtc_tick | input | 1 | One-cycle strobe at the real-time clock rate |
| cfg_mode | input | 2 | Filter mode: 00 pass, 01 keep low, 10 keep high, 11 reject both |
| cfg_count | input | 4 | Units of stability needed |
| cfg_large | input | 1 | Time-base select, upper bit |
| cfg_unit | input | 1 | Time-base select, lower bit |
| pin_raw | input | 1 | Asynchronous pin level |
| pin_level | output | 1 | Filtered level seen as pin status |

## Verification
The properties assume that `rtc_tick` is a strobe in the clock domain and that the configuration bits change only at clock edges. The bench drives all inputs at the falling edge, so both assumptions hold. The three-edge latency properties also assume that the raw pin has been sampled for at least four clocks since reset, and a cycle counter in the checker gates them until then. The stimulus never places a tick in the same cycle as a configuration write. This keeps each reload window clean and easy to observe.

// File: rtl/deglitch_pkg.sv
package deglitch_pkg;

  typedef enum logic [1:0] {
    DG_PASS      = 2'b00,
    DG_KEEP_LOW  = 2'b01,
    DG_KEEP_HIGH = 2'b10,
    DG_REJECT    = 2'b11
  } dg_mode_e;

  function automatic int unsigned dg_max4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/deglitch_sync.sv
module deglitch_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/deglitch_timebase.sv
module deglitch_timebase #(
  parameter int unsigned TICKS_U0 = 2,
  parameter int unsigned TICKS_U1 = 8,
  parameter int unsigned TICKS_U2 = 512,
  parameter int unsigned TICKS_U3 = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       run,
  input  logic [1:0] unit_sel,
  output logic       unit_done
);
  import deglitch_pkg::*;

  localparam int unsigned TICK_MAX = dg_max4(TICKS_U0, TICKS_U1, TICKS_U2, TICKS_U3);
  localparam int unsigned PRE_W    = (TICK_MAX > 2) ? $clog2(TICK_MAX) : 1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] last_idx;

  always_comb begin
    case (unit_sel)
      2'b00:   last_idx = PRE_W'(TICKS_U0 - 1);
      2'b01:   last_idx = PRE_W'(TICKS_U1 - 1);
      2'b10:   last_idx = PRE_W'(TICKS_U2 - 1);
      default: last_idx = PRE_W'(TICKS_U3 - 1);
    endcase
  end

  assign unit_done = run && (pre_q == last_idx);

  always_comb begin
    pre_d = pre_q;
    if (clr)            pre_d = '0;
    else if (unit_done) pre_d = '0;
    else if (run)       pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/deglitch_stab.sv
module deglitch_stab #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] stab_q, stab_d;

  assign expire = step && (stab_q == (limit - 1'b1));

  always_comb begin
    stab_d = stab_q;
    if (clr || expire) stab_d = '0;
    else if (step)     stab_d = stab_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stab_q <= '0;
    else        stab_q <= stab_d;
  end
endmodule

// File: rtl/gpio_deglitch.sv
module gpio_deglitch #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned TICKS_U0    = 2,
  parameter int unsigned TICKS_U1    = 8,
  parameter int unsigned TICKS_U2    = 512,
  parameter int unsigned TICKS_U3    = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rtc_tick,
  input  logic [1:0]       cfg_mode,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             cfg_large,
  input  logic             cfg_unit,
  input  logic             pin_raw,
  output logic             pin_level
);
  import deglitch_pkg::*;

  localparam int unsigned CFG_W = 2 + CNT_W + 2;

  logic             in_s;
  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic             cfg_chg;
  logic             lvl_q, lvl_d;
  logic             differ, fast_path, no_delay, pending;
  logic             unit_done, expire;
  dg_mode_e         mode;

  assign mode    = dg_mode_e'(cfg_mode);
  assign cfg_now = {cfg_mode, cfg_count, cfg_large, cfg_unit};
  assign cfg_chg = (cfg_now != cfg_q);

  deglitch_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_raw),
    .q_sync  (in_s)
  );

  assign differ    = (in_s != lvl_q);
  assign fast_path = ((mode == DG_KEEP_LOW)  && !in_s) ||
                     ((mode == DG_KEEP_HIGH) &&  in_s);
  assign no_delay  = (cfg_count == '0);
  assign pending   = (mode != DG_PASS) && differ && !fast_path && !no_delay && !cfg_chg;

  deglitch_timebase #(
    .TICKS_U0 (TICKS_U0),
    .TICKS_U1 (TICKS_U1),
    .TICKS_U2 (TICKS_U2),
    .TICKS_U3 (TICKS_U3)
  ) u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (!pending),
    .run       (pending && rtc_tick),
    .unit_sel  ({cfg_large, cfg_unit}),
    .unit_done (unit_done)
  );

  deglitch_stab #(.CNT_W(CNT_W)) u_stab (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!pending),
    .step   (unit_done),
    .limit  (cfg_count),
    .expire (expire)
  );

  always_comb begin
    lvl_d = lvl_q;
    if (cfg_chg)                    lvl_d = lvl_q;
    else if (mode == DG_PASS)       lvl_d = in_s;
    else if (!differ)               lvl_d = lvl_q;
    else if (fast_path || no_delay) lvl_d = in_s;
    else if (expire)                lvl_d = in_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cfg_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cfg_q <= cfg_now;
    end
  end

  assign pin_level = lvl_q;
endmodule

// File: rtl/gpio_deglitch_chk.sv
module gpio_deglitch_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rtc_tick,
  input logic [1:0]       cfg_mode,
  input logic [CNT_W-1:0] cfg_count,
  input logic             cfg_large,
  input logic             cfg_unit,
  input logic             pin_raw,
  input logic             pin_level
);
  logic [2:0]         up_q;
  logic [CNT_W+3:0]   cfg_seen_q;
  logic               chg;

  assign chg = ({cfg_mode, cfg_count, cfg_large, cfg_unit} != cfg_seen_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q       <= '0;
      cfg_seen_q <= '0;
    end else begin
      if (up_q != 3'd7) up_q <= up_q + 3'd1;
      cfg_seen_q <= {cfg_mode, cfg_count, cfg_large, cfg_unit};
    end
  end

  assert_reset_low_R1: assert property (@(posedge clk) !rst_n |=> !pin_level);

  assert_three_edge_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q >= 3'd4 && pin_level != $past(pin_level)) |-> pin_level == $past(pin_raw, 3));

  assert_pass_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q >= 3'd4 && cfg_mode == 2'b00 && !chg) |=> pin_level == $past(pin_raw, 3));

  assert_reject_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b11 && cfg_count != '0 && !rtc_tick) |=> $stable(pin_level));

  assert_keep_low_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b01 && cfg_count != '0 && !rtc_tick) |=> !$rose(pin_level));

  assert_keep_high_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b10 && cfg_count != '0 && !rtc_tick) |=> !$fell(pin_level));

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> $stable(pin_level));
endmodule

bind gpio_deglitch gpio_deglitch_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rtc_tick  (rtc_tick),
  .cfg_mode  (cfg_mode),
  .cfg_count (cfg_count),
  .cfg_large (cfg_large),
  .cfg_unit  (cfg_unit),
  .pin_raw   (pin_raw),
  .pin_level (pin_level)
);

// File: tb/sim_gpio_deglitch.sv
`timescale 1ns/1ps
module sim_gpio_deglitch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rtc_tick = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic [3:0] cfg_count = 4'd0;
  logic       cfg_large = 1'b0;
  logic       cfg_unit = 1'b0;
  logic       pin_raw = 1'b0;
  logic       pin_level;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_deglitch u0 (
    .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .cfg_mode(cfg_mode),
    .cfg_count(cfg_count), .cfg_large(cfg_large), .cfg_unit(cfg_unit),
    .pin_raw(pin_raw), .pin_level(pin_level)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pin_level actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk) rtc_tick = 1'b1;
      @(negedge clk) rtc_tick = 1'b0;
    end
  endtask

  task automatic settle(input logic lvl);
    cfg_mode = 2'b00; pin_raw = lvl;
    cycles(5);
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic [3:0] c, input logic lg, input logic un);
    cfg_mode = m; cfg_count = c; cfg_large = lg; cfg_unit = un;
    cycles(2);
  endtask

  task automatic t_reset;
    check("R1 in reset", pin_level, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    cycles(2);
    check("R1 after release", pin_level, 1'b0);
  endtask

  task automatic t_pass;
    pin_raw = 1'b1;
    rtc_tick = 1'b1;
    cycles(2);
    check("R3 two edges", pin_level, 1'b0);
    cycles(1);
    check("R3 three edges (R2)", pin_level, 1'b1);
    rtc_tick = 1'b0;
    pin_raw = 1'b0;
    cycles(3);
    check("R3 fall", pin_level, 1'b0);
  endtask

  task automatic t_reject;
    settle(1'b0);
    set_cfg(2'b11, 4'd3, 1'b0, 1'b0);
    pin_raw = 1'b1; cycles(3);
    check("R5 no tick", pin_level, 1'b0);
    ticks(5);
    check("R5 rise 5 of 6", pin_level, 1'b0);
    ticks(1);
    check("R5 rise 6 of 6", pin_level, 1'b1);
    pin_raw = 1'b0; cycles(3);
    ticks(5);
    check("R5 fall 5 of 6", pin_level, 1'b1);
    ticks(1);
    check("R5 fall 6 of 6", pin_level, 1'b0);
  endtask

  task automatic t_glitch;
    settle(1'b0);
    set_cfg(2'b11, 4'd2, 1'b0, 1'b0);
    pin_raw = 1'b1; cycles(3);
    ticks(3);
    pin_raw = 1'b0; cycles(3);
    check("R6 short pulse rejected", pin_level, 1'b0);
    pin_raw = 1'b1; cycles(3);
    ticks(3);
    check("R6 restart 3 of 4", pin_level, 1'b0);
    ticks(1);
    check("R6 restart 4 of 4", pin_level, 1'b1);
  endtask

  task automatic t_keep_low;
    settle(1'b1);
    set_cfg(2'b01, 4'd2, 1'b0, 1'b0);
    pin_raw = 1'b0; cycles(2);
    check("R7 fall not before three edges", pin_level, 1'b1);
    cycles(1);
    check("R7 fall immediate", pin_level, 1'b0);
    pin_raw = 1'b1; cycles(3);
    ticks(3);
    check("R7 rise 3 of 4", pin_level, 1'b0);
    ticks(1);
    check("R7 rise 4 of 4", pin_level, 1'b1);
  endtask

  task automatic t_keep_high;
    settle(1'b0);
    set_cfg(2'b10, 4'd2, 1'b0, 1'b0);
    pin_raw = 1'b1; cycles(3);
    check("R8 rise immediate", pin_level, 1'b1);
    pin_raw = 1'b0; cycles(3);
    ticks(3);
    check("R8 fall 3 of 4", pin_level, 1'b1);
    ticks(1);
    check("R8 fall 4 of 4", pin_level, 1'b0);
  endtask

  task automatic t_unit(input logic lg, input logic un, input int per);
    settle(1'b0);
    set_cfg(2'b11, 4'd1, lg, un);
    pin_raw = 1'b1; cycles(3);
    ticks(per - 1);
    check($sformatf("R4 unit %0d one short", per), pin_level, 1'b0);
    ticks(1);
    check($sformatf("R4 unit %0d exact", per), pin_level, 1'b1);
  endtask

  task automatic t_zero;
    settle(1'b0);
    set_cfg(2'b11, 4'd0, 1'b0, 1'b0);
    pin_raw = 1'b1; cycles(3);
    check("R9 zero count rise", pin_level, 1'b1);
    pin_raw = 1'b0; cycles(3);
    check("R9 zero count fall", pin_level, 1'b0);
  endtask

  task automatic t_reload;
    settle(1'b0);
    set_cfg(2'b11, 4'd2, 1'b0, 1'b0);
    pin_raw = 1'b1; cycles(3);
    ticks(3);
    cfg_count = 4'd3;
    cycles(1);
    check("R10 held on write", pin_level, 1'b0);
    ticks(5);
    check("R10 reloaded 5 of 6", pin_level, 1'b0);
    ticks(1);
    check("R10 reloaded 6 of 6", pin_level, 1'b1);
  endtask

  task automatic t_max;
    settle(1'b0);
    set_cfg(2'b11, 4'd15, 1'b0, 1'b0);
    pin_raw = 1'b1; cycles(3);
    ticks(29);
    check("R11 29 of 30", pin_level, 1'b0);
    ticks(1);
    check("R11 30 of 30", pin_level, 1'b1);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cycles(3);
    t_reset();
    t_pass();
    t_reject();
    t_glitch();
    t_keep_low();
    t_keep_high();
    t_unit(1'b0, 1'b0, 2);
    t_unit(1'b0, 1'b1, 8);
    t_unit(1'b1, 1'b0, 512);
    t_unit(1'b1, 1'b1, 2048);
    t_zero();
    t_reload();
    t_max();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule